// File: doc/BRIEF.md
# FIFO Event Interrupt and Status Unit

This unit watches the fill levels of a serial controller's transmit and receive FIFOs (63 words deep) together with two error events, keeps a sticky status word, and drives a single interrupt line. Software sees it through a small register bus. It reads and clears the status word. It sets and clears an interrupt mask through two write-only registers, and reads that mask back through a third, read-only register. It also programs two watermarks that decide when the transmit side counts as "low" and when the receive side counts as "holding data".

Error events are latched from two input pulses. One is a receive push that arrives while the receive FIFO is already full. The other is a transmit pop that arrives while the transmit FIFO is already empty. Level flags are raised whenever their condition holds. Every status bit stays set until software writes a 1 to it. A level flag cannot be cleared while its condition still holds. The FIFO storage and the serial engine sit outside the unit.

The register bus has no back-pressure. The unit accepts every request in the cycle it is presented. A read returns its data one cycle later, marked by a one-cycle valid strobe.

Top module: `fisc_irq_ctrl`

## Requirements
- R1: After reset the status word and the mask are 0, the interrupt is low, and both watermarks (TX at offset 0x28, RX at offset 0x2C) read 1.
- R2: Status bit 0 (RX overflow) is set on the cycle after a receive push arrives while the receive level is 63. It then stays set until it is cleared.
- R3: Status bit 6 (TX underflow) is set on the cycle after a transmit pop arrives while the transmit level is 0. It then stays set until it is cleared. A pop at a non-zero level does not set it.
- R4: Status bit 2 (TX low) is raised while the transmit level is below the TX watermark. With the watermark at 1, this means the transmit FIFO is empty.
- R5: Status bit 3 (TX full) is raised while the transmit level equals 63. Status bit 5 (RX full) is raised while the receive level equals 63.
- R6: Status bit 4 (RX has data) is raised while the receive level is non-zero and at least the RX watermark.
- R7: A level bit stays set after its condition ends. A clear of that bit has no effect in any cycle where its condition holds.
- R8: Writing to the status word at offset 0x04 clears each bit written as 1 and leaves bits written as 0 unchanged. When an event and its clear land in the same cycle, the event wins.
- R9: Writing to offset 0x08 sets each mask bit written as 1. Writing to offset 0x0C clears each mask bit written as 1. The mask reads back at offset 0x10.
- R10: Offsets 0x08, 0x0C and any unmapped offset read 0. A write to 0x10 has no effect. Bit 1 and bits 7 and above are never stored and read 0.
- R11: The interrupt is high exactly when some status bit and its mask bit are both 1. It changes in the cycle after the register change that causes it.
- R12: Read data is presented with `bus_rvalid` high for one cycle, one cycle after the read request. Write requests produce no valid strobe.

Bit layout shared by status and mask: 0 RX overflow, 2 TX low, 3 TX full, 4 RX has data, 5 RX full, 6 TX underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | Receive FIFO push attempt |
| tx_pop | input | 1 | Transmit FIFO pop attempt |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- **Clearing a level flag while its condition holds.** A design that ignored the condition would drop an empty-FIFO flag that software must still see.
- **Clear and event in the same cycle.** A design that gave the clear priority would lose an overflow.
- **Watermark boundaries on both FIFOs.** An off-by-one compare would fire one word early or late.
- **Mask behaviour.** Writes to the read-only mask, and set or clear writes that carry reserved bits, must be ignored. A wrong decode would corrupt the mask or change `irq` when it should not.
- **Interrupt timing.** `irq` is sampled both before and after each event and each mask change, so a missing or extra register stage shows up as a one-cycle error.

// File: rtl/fisc_pkg.sv
package fisc_pkg;
  localparam int unsigned STAT_W = 7;

  localparam int unsigned BIT_RX_OVF   = 0;
  localparam int unsigned BIT_TX_LOW   = 2;
  localparam int unsigned BIT_TX_FULL  = 3;
  localparam int unsigned BIT_RX_AVAIL = 4;
  localparam int unsigned BIT_RX_FULL  = 5;
  localparam int unsigned BIT_TX_UNF   = 6;

  // implemented bits of the shared status/mask layout
  localparam logic [STAT_W-1:0] IMPL_MASK = 7'b111_1101;

  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_ENA    = 8'h08;
  localparam logic [7:0] OFS_DIS    = 8'h0C;
  localparam logic [7:0] OFS_MASK   = 8'h10;
  localparam logic [7:0] OFS_TXWM   = 8'h28;
  localparam logic [7:0] OFS_RXWM   = 8'h2C;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_EVENT,
    KIND_LEVEL
  } bit_kind_e;

  function automatic bit_kind_e kind_of(int unsigned b);
    case (b)
      BIT_RX_OVF, BIT_TX_UNF:                          return KIND_EVENT;
      BIT_TX_LOW, BIT_TX_FULL, BIT_RX_AVAIL, BIT_RX_FULL: return KIND_LEVEL;
      default:                                         return KIND_NONE;
    endcase
  endfunction

  typedef struct packed {
    logic stat_clr;
    logic msk_set;
    logic msk_clr;
    logic txwm_wr;
    logic rxwm_wr;
  } wr_dec_t;
endpackage

// File: rtl/fisc_cond.sv
module fisc_cond
  import fisc_pkg::*;
#(
  parameter int unsigned DEPTH = 63,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_wm,
  input  logic [LVL_W-1:0]  rx_wm,
  input  logic              rx_push,
  input  logic              tx_pop,
  output logic [STAT_W-1:0] raise
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic rx_is_full, tx_is_full, tx_is_empty;

  assign rx_is_full  = (rx_level == FULL_LVL);
  assign tx_is_full  = (tx_level == FULL_LVL);
  assign tx_is_empty = (tx_level == '0);

  always_comb begin
    raise               = '0;
    raise[BIT_RX_OVF]   = rx_push && rx_is_full;
    raise[BIT_TX_LOW]   = (tx_level < tx_wm);
    raise[BIT_TX_FULL]  = tx_is_full;
    raise[BIT_RX_AVAIL] = (rx_level != '0) && (rx_level >= rx_wm);
    raise[BIT_RX_FULL]  = rx_is_full;
    raise[BIT_TX_UNF]   = tx_pop && tx_is_empty;
  end
endmodule

// File: rtl/fisc_sticky.sv
module fisc_sticky
  import fisc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] raise,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] status
);
  for (genvar g = 0; g < STAT_W; g++) begin : g_bit
    if (kind_of(g) == KIND_NONE) begin : g_rsvd
      assign status[g] = 1'b0;
    end else begin : g_live
      logic bit_q;
      logic bit_d;
      // an event pulse or a holding level both dominate a clear
      always_comb begin
        if (kind_of(g) == KIND_EVENT)
          bit_d = raise[g] | (bit_q & ~clr[g]);
        else
          bit_d = raise[g] | (bit_q & ~(clr[g] & ~raise[g]));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign status[g] = bit_q;
    end
  end
endmodule

// File: rtl/fisc_regs.sv
module fisc_regs
  import fisc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LVL_W     = 6,
  parameter int unsigned TX_WM_RST = 1,
  parameter int unsigned RX_WM_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] stat_clr,
  output logic [STAT_W-1:0] mask_q,
  output logic [LVL_W-1:0]  tx_wm,
  output logic [LVL_W-1:0]  rx_wm,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int unsigned PAD_S = DATA_W - STAT_W;
  localparam int unsigned PAD_L = DATA_W - LVL_W;

  logic          wr_hit, rd_hit;
  wr_dec_t       dec;
  logic [STAT_W-1:0] wbits;

  assign wr_hit = bus_sel && bus_wr;
  assign rd_hit = bus_sel && !bus_wr;
  assign wbits  = bus_wdata[STAT_W-1:0] & IMPL_MASK;

  always_comb begin
    dec          = '0;
    dec.stat_clr = wr_hit && (bus_addr == ADDR_W'(OFS_STATUS));
    dec.msk_set  = wr_hit && (bus_addr == ADDR_W'(OFS_ENA));
    dec.msk_clr  = wr_hit && (bus_addr == ADDR_W'(OFS_DIS));
    dec.txwm_wr  = wr_hit && (bus_addr == ADDR_W'(OFS_TXWM));
    dec.rxwm_wr  = wr_hit && (bus_addr == ADDR_W'(OFS_RXWM));
  end

  assign stat_clr = dec.stat_clr ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (dec.msk_set) begin
      mask_q <= mask_q | wbits;
    end else if (dec.msk_clr) begin
      mask_q <= mask_q & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wm <= LVL_W'(TX_WM_RST);
      rx_wm <= LVL_W'(RX_WM_RST);
    end else begin
      if (dec.txwm_wr) tx_wm <= bus_wdata[LVL_W-1:0];
      if (dec.rxwm_wr) rx_wm <= bus_wdata[LVL_W-1:0];
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_STATUS))    rd_mux = {{PAD_S{1'b0}}, status};
    else if (bus_addr == ADDR_W'(OFS_MASK)) rd_mux = {{PAD_S{1'b0}}, mask_q};
    else if (bus_addr == ADDR_W'(OFS_TXWM)) rd_mux = {{PAD_L{1'b0}}, tx_wm};
    else if (bus_addr == ADDR_W'(OFS_RXWM)) rd_mux = {{PAD_L{1'b0}}, rx_wm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_hit;
      if (rd_hit) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/fisc_irq_ctrl.sv
module fisc_irq_ctrl
  import fisc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 63,
  parameter int unsigned TX_WM_RST = 1,
  parameter int unsigned RX_WM_RST = 1,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_push,
  input  logic              tx_pop,
  output logic              irq
);
  logic [STAT_W-1:0] raise, stat_clr, status, mask_q;
  logic [LVL_W-1:0]  tx_wm, rx_wm;

  fisc_cond #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cond (
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_wm(tx_wm), .rx_wm(rx_wm),
    .rx_push(rx_push), .tx_pop(tx_pop),
    .raise(raise)
  );

  fisc_sticky u_sticky (
    .clk(clk), .rst_n(rst_n),
    .raise(raise), .clr(stat_clr),
    .status(status)
  );

  fisc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
    .TX_WM_RST(TX_WM_RST), .RX_WM_RST(RX_WM_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status(status), .stat_clr(stat_clr), .mask_q(mask_q),
    .tx_wm(tx_wm), .rx_wm(rx_wm),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  assign irq = |(status & mask_q);
endmodule

// File: rtl/fisc_checker.sv
module fisc_checker
  import fisc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 63,
  parameter int unsigned LVL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rx_push,
  input logic              tx_pop,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] mask_q,
  input logic              irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic wr_ena, wr_dis, wr_msk, rd_req;
  assign wr_ena = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_ENA));
  assign wr_dis = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DIS));
  assign wr_msk = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
  assign rd_req = bus_sel && !bus_wr;

  assert_ovf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == FULL_LVL) |=> status[BIT_RX_OVF]);

  assert_unf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_level == '0) |=> status[BIT_TX_UNF]);

  assert_txfull_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == FULL_LVL) |=> status[BIT_TX_FULL]);

  assert_rxfull_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == FULL_LVL) |=> status[BIT_RX_FULL]);

  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_TX_FULL] && tx_level == FULL_LVL) |=> status[BIT_TX_FULL]);

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((mask_q & $past(bus_wdata[STAT_W-1:0]) & IMPL_MASK)
                == ($past(bus_wdata[STAT_W-1:0]) & IMPL_MASK)));

  assert_mask_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((mask_q & $past(bus_wdata[STAT_W-1:0])) == '0));

  assert_mask_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msk |=> $stable(mask_q));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  assert_no_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
endmodule

bind fisc_irq_ctrl fisc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .tx_level(tx_level), .rx_level(rx_level),
  .rx_push(rx_push), .tx_pop(tx_pop),
  .status(status), .mask_q(mask_q), .irq(irq)
);

// File: tb/fisc_irq_ctrl_bench.sv
module fisc_irq_ctrl_bench;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LVL_W  = 6;

  localparam logic [7:0] A_STAT = 8'h04, A_ENA = 8'h08, A_DIS = 8'h0C,
                         A_MASK = 8'h10, A_TXWM = 8'h28, A_RXWM = 8'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic bus_rvalid;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic rx_push = 1'b0, tx_pop = 1'b0;
  logic irq;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #2.5 clk = ~clk;

  fisc_irq_ctrl u_fisc_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_level(tx_level), .rx_level(rx_level),
    .rx_push(rx_push), .tx_pop(tx_pop), .irq(irq)
  );

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // monitor: pops the scoreboard whenever read data comes back
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic rd(logic [7:0] a, logic [DATA_W-1:0] e, string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse_push();
    rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pulse_pop();
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_TXWM, 32'd1, "R1 tx watermark");
    rd(A_RXWM, 32'd1, "R1 rx watermark");
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(A_STAT, 32'h04, "R4 empty tx with watermark 1");

    // R7 sticky level, R8 clear
    tx_level = 6'd10;
    rd(A_STAT, 32'h04, "R7 level bit held");
    wr(A_STAT, 32'h04);
    rd(A_STAT, 32'h00, "R8 w1c clears");
    tx_level = 6'd0;
    rd(A_STAT, 32'h04, "R4 tx empty again");
    wr(A_STAT, 32'h04);
    rd(A_STAT, 32'h04, "R7 clear ignored while condition holds");

    // R4 watermark compare
    tx_level = 6'd10;
    wr(A_TXWM, 32'd16);
    wr(A_STAT, 32'h04);
    rd(A_STAT, 32'h04, "R4 level 10 below watermark 16");
    wr(A_TXWM, 32'd4);
    wr(A_STAT, 32'h04);
    rd(A_STAT, 32'h00, "R4 level 10 not below watermark 4");
    rd(A_TXWM, 32'd4, "R4 tx watermark readback");

    // R5 tx full
    tx_level = 6'd63;
    rd(A_STAT, 32'h08, "R5 tx full");
    tx_level = 6'd5;
    wr(A_STAT, 32'h08);
    rd(A_STAT, 32'h00, "R5 tx full cleared");

    // R6 rx watermark
    rx_level = 6'd1;
    rd(A_STAT, 32'h10, "R6 rx has data at watermark 1");
    wr(A_RXWM, 32'd8);
    rx_level = 6'd3;
    wr(A_STAT, 32'h10);
    rd(A_STAT, 32'h00, "R6 level 3 below rx watermark 8");
    rx_level = 6'd8;
    rd(A_STAT, 32'h10, "R6 level equal to rx watermark");

    // R5 rx full, R2 overflow, R8 partial and same-cycle clear
    rx_level = 6'd63;
    rd(A_STAT, 32'h30, "R5 rx full");
    pulse_push();
    rd(A_STAT, 32'h31, "R2 overflow set");
    rx_level = 6'd0;
    wr(A_STAT, 32'h30);
    rd(A_STAT, 32'h01, "R8 partial clear keeps overflow");
    rx_level = 6'd63;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h01;
    rx_push = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; rx_push = 1'b0;
    rd(A_STAT, 32'h31, "R8 event wins over clear");
    rx_level = 6'd0;
    wr(A_STAT, 32'h7F);
    rd(A_STAT, 32'h00, "R8 clear all");

    // R3 underflow
    wr(A_TXWM, 32'd1);
    tx_level = 6'd5;
    pulse_pop();
    rd(A_STAT, 32'h00, "R3 pop at nonzero level");
    tx_level = 6'd0;
    pulse_pop();
    rd(A_STAT, 32'h44, "R3 underflow set");
    tx_level = 6'd5;
    wr(A_STAT, 32'h04);
    rd(A_STAT, 32'h40, "R3 underflow sticky");
    wr(A_STAT, 32'h40);
    rd(A_STAT, 32'h00, "R3 underflow cleared");

    // R9/R10 mask registers
    wr(A_ENA, 32'h41);
    rd(A_MASK, 32'h41, "R9 enable sets mask");
    rd(A_ENA, 32'h0, "R10 enable reads zero");
    rd(A_DIS, 32'h0, "R10 disable reads zero");
    wr(A_MASK, 32'h7F);
    rd(A_MASK, 32'h41, "R10 mask write ignored");
    check("R11 irq low with empty status", {31'd0, irq}, 32'd0);

    // R11 irq
    tx_level = 6'd0;
    tx_pop = 1'b1;
    check("R11 irq before event", {31'd0, irq}, 32'd0);
    @(negedge clk);
    tx_pop = 1'b0;
    check("R11 irq after underflow", {31'd0, irq}, 32'd1);
    wr(A_DIS, 32'h40);
    check("R11 irq low after disable", {31'd0, irq}, 32'd0);
    rd(A_MASK, 32'h01, "R9 disable clears mask");
    wr(A_ENA, 32'h04);
    check("R11 irq from tx low", {31'd0, irq}, 32'd1);
    tx_level = 6'd5;
    wr(A_STAT, 32'h40);
    check("R11 irq held by tx low", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h04);
    check("R11 irq clears", {31'd0, irq}, 32'd0);

    // R10 reserved bits and unmapped offset
    wr(A_ENA, 32'hFFFF_FF82);
    rd(A_MASK, 32'h05, "R10 reserved mask bits dropped");
    rd(8'h00, 32'h0, "R10 unmapped offset");

    // R12 read strobe timing
    @(negedge clk);
    check("R12 rvalid idle", {31'd0, bus_rvalid}, 32'd0);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_MASK;
    exp_q.push_back(32'h05); tag_q.push_back("R12 read data");
    @(negedge clk);
    bus_sel = 1'b0;
    check("R12 rvalid one cycle after request", {31'd0, bus_rvalid}, 32'd1);
    @(negedge clk);
    check("R12 rvalid single cycle", {31'd0, bus_rvalid}, 32'd0);
    wr(A_DIS, 32'h7F);
    check("R12 no strobe on write", {31'd0, bus_rvalid}, 32'd0);

    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", exp_q.size(), 32'd0);
    summary();
  end
endmodule